// File: doc/BRIEF.md
# Multi-Offset Sum of Absolute Differences Unit

This block is a packed SIMD datapath that measures how well a short 4-byte reference pattern matches eight overlapping positions of a longer byte row. It takes two 128-bit operands and treats each one as sixteen unsigned bytes. The first operand supplies a row of eleven bytes. The second operand supplies the four-byte reference group. A 3-bit control field picks the part of each operand that is used.

Each of the eight windows over the row starts one byte after the previous window. For each window the unit adds the four absolute byte differences against the reference group. The eight sums are packed into a 128-bit result, with one 16-bit lane per window. Motion-estimation and block-matching engines use this to score several candidate offsets in a single operation.

Inputs are qualified by `in_valid` and results by `out_valid`. A parameter adds one register stage between the difference stage and the adder tree. With that stage the result appears one clock after the operands. Without it the result is combinational.

Top module: `msad_unit`

## Requirements
- R1: For window k in 0..7, lane k equals |w[k]−r[0]| + |w[k+1]−r[1]| + |w[k+2]−r[2]| + |w[k+3]−r[3]|. Here w is the selected 11-byte row from `src_a` and r is the selected 4-byte group from `src_b`.
- R2: `ctrl[2]` = 0 takes the row from bytes 0..10 of `src_a`. `ctrl[2]` = 1 takes it from bytes 4..14. Byte i is bits [8i+7:8i].
- R3: `ctrl[1:0]` = g takes the reference group from bytes 4g..4g+3 of `src_b`, in ascending order r[0]..r[3].
- R4: All bytes are unsigned values from 0 to 255. Each lane is a 16-bit unsigned sum no larger than 1020, with zero in the unused upper bits. Lane k sits at bits [16k+15:16k] of `sad_out`.
- R5: With `PIPE_EN` = 1, `out_valid` in each cycle equals the `in_valid` of the previous cycle. The lanes shown with it come from the operands of that previous cycle.
- R6: With `PIPE_EN` = 1, `sad_out` does not change in a cycle that follows a cycle with `in_valid` low.
- R7: A synchronous active-high `rst` makes `out_valid` low in the next cycle.
- R8: With `PIPE_EN` = 0, `out_valid` follows `in_valid` and `sad_out` reflects the current operands in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and control are valid |
| ctrl | input | 3 | Bit 2 selects the row base; bits 1:0 select the reference group |
| src_a | input | 128 | Row operand, sixteen unsigned bytes |
| src_b | input | 128 | Reference operand, sixteen unsigned bytes |
| out_valid | output | 1 | Result is valid |
| sad_out | output | 128 | Eight 16-bit sums; lane k at [16k+15:16k] |

## Verification
The bench builds two copies of the unit side by side. One has `PIPE_EN` = 1 and the other `PIPE_EN` = 0, so both the registered one-cycle path and the combinational path are checked against the same reference function.

In the registered copy the operands are replaced with random data while `in_valid` is low, so any result that is not held stands out. A reset is also asserted together with a valid input. The directed patterns reach the 1020 upper bound, all-zero rows and every one of the eight control codes. Ramp and single-byte patterns expose any error in offset or group selection.

// File: rtl/msad_pkg.sv
package msad_pkg;

  localparam int unsigned ELEM_W = 8;

  typedef logic [ELEM_W-1:0] elem_t;

  // Larger minus smaller: never negative, never wider than an element.
  function automatic elem_t abs_diff(input elem_t x, input elem_t y);
    return (x >= y) ? elem_t'(x - y) : elem_t'(y - x);
  endfunction

endpackage

// File: rtl/msad_select.sv
module msad_select import msad_pkg::*; #(
  parameter int unsigned OPND_LANES = 16,
  parameter int unsigned NUM_SUMS   = 8,
  parameter int unsigned GROUP_LEN  = 4,
  localparam int unsigned WIN_LEN   = NUM_SUMS + GROUP_LEN - 1
) (
  input  logic [2:0]                             ctrl,
  input  logic [OPND_LANES-1:0][ELEM_W-1:0]      a_lanes,
  input  logic [OPND_LANES-1:0][ELEM_W-1:0]      b_lanes,
  output logic [WIN_LEN-1:0][ELEM_W-1:0]         row,
  output logic [GROUP_LEN-1:0][ELEM_W-1:0]       refgrp
);

  localparam int unsigned ROW_SHIFT = GROUP_LEN;

  int unsigned row_base;
  int unsigned grp_base;

  always_comb begin
    row_base = ctrl[2] ? ROW_SHIFT : 0;
    grp_base = int'(ctrl[1:0]) * GROUP_LEN;
  end

  genvar i;
  generate
    for (i = 0; i < WIN_LEN; i++) begin : g_row
      assign row[i] = a_lanes[row_base + i];
    end
    for (i = 0; i < GROUP_LEN; i++) begin : g_ref
      assign refgrp[i] = b_lanes[grp_base + i];
    end
  endgenerate

endmodule

// File: rtl/msad_diff.sv
module msad_diff import msad_pkg::*; #(
  parameter int unsigned NUM_SUMS  = 8,
  parameter int unsigned GROUP_LEN = 4,
  localparam int unsigned WIN_LEN  = NUM_SUMS + GROUP_LEN - 1
) (
  input  logic [WIN_LEN-1:0][ELEM_W-1:0]                    row,
  input  logic [GROUP_LEN-1:0][ELEM_W-1:0]                  refgrp,
  output logic [NUM_SUMS-1:0][GROUP_LEN-1:0][ELEM_W-1:0]    diffs
);

  genvar k, j;
  generate
    for (k = 0; k < NUM_SUMS; k++) begin : g_win
      for (j = 0; j < GROUP_LEN; j++) begin : g_elem
        assign diffs[k][j] = abs_diff(row[k + j], refgrp[j]);
      end
    end
  endgenerate

endmodule

// File: rtl/msad_stage.sv
module msad_stage import msad_pkg::*; #(
  parameter int unsigned NUM_SUMS  = 8,
  parameter int unsigned GROUP_LEN = 4,
  parameter bit          PIPE_EN   = 1'b1
) (
  input  logic                                              clk,
  input  logic                                              rst,
  input  logic                                              load,
  input  logic [NUM_SUMS-1:0][GROUP_LEN-1:0][ELEM_W-1:0]    d_in,
  output logic                                              v_out,
  output logic [NUM_SUMS-1:0][GROUP_LEN-1:0][ELEM_W-1:0]    d_out
);

  generate
    if (PIPE_EN) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          v_out <= 1'b0;
          d_out <= '0;
        end else begin
          v_out <= load;
          if (load) d_out <= d_in;
        end
      end
    end else begin : g_pass
      assign v_out = load;
      assign d_out = d_in;
    end
  endgenerate

endmodule

// File: rtl/msad_sum.sv
module msad_sum import msad_pkg::*; #(
  parameter int unsigned NUM_SUMS  = 8,
  parameter int unsigned GROUP_LEN = 4,
  parameter int unsigned SUM_W     = 16
) (
  input  logic [NUM_SUMS-1:0][GROUP_LEN-1:0][ELEM_W-1:0]  diffs,
  output logic [NUM_SUMS-1:0][SUM_W-1:0]                  sums
);

  function automatic logic [SUM_W-1:0] add_group(
    input logic [GROUP_LEN-1:0][ELEM_W-1:0] g);
    logic [SUM_W-1:0] acc;
    acc = '0;
    for (int j = 0; j < GROUP_LEN; j++) acc = acc + SUM_W'(g[j]);
    return acc;
  endfunction

  genvar k;
  generate
    for (k = 0; k < NUM_SUMS; k++) begin : g_lane
      assign sums[k] = add_group(diffs[k]);
    end
  endgenerate

endmodule

// File: rtl/msad_unit.sv
module msad_unit import msad_pkg::*; #(
  parameter int unsigned OPND_LANES = 16,
  parameter int unsigned NUM_SUMS   = 8,
  parameter int unsigned GROUP_LEN  = 4,
  parameter int unsigned SUM_W      = 16,
  parameter bit          PIPE_EN    = 1'b1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           in_valid,
  input  logic [2:0]                     ctrl,
  input  logic [OPND_LANES*ELEM_W-1:0]   src_a,
  input  logic [OPND_LANES*ELEM_W-1:0]   src_b,
  output logic                           out_valid,
  output logic [NUM_SUMS*SUM_W-1:0]      sad_out
);

  localparam int unsigned WIN_LEN = NUM_SUMS + GROUP_LEN - 1;

  logic [OPND_LANES-1:0][ELEM_W-1:0]              a_lanes, b_lanes;
  logic [WIN_LEN-1:0][ELEM_W-1:0]                 row;
  logic [GROUP_LEN-1:0][ELEM_W-1:0]               refgrp;
  logic [NUM_SUMS-1:0][GROUP_LEN-1:0][ELEM_W-1:0] diffs_now, diffs_held;
  logic [NUM_SUMS-1:0][SUM_W-1:0]                 sums;

  // Named event for the checker: the stage captures new differences.
  logic stage_load;
  assign stage_load = in_valid;

  assign a_lanes = src_a;
  assign b_lanes = src_b;

  msad_select #(.OPND_LANES(OPND_LANES), .NUM_SUMS(NUM_SUMS), .GROUP_LEN(GROUP_LEN)) u_sel (
    .ctrl(ctrl), .a_lanes(a_lanes), .b_lanes(b_lanes), .row(row), .refgrp(refgrp));

  msad_diff #(.NUM_SUMS(NUM_SUMS), .GROUP_LEN(GROUP_LEN)) u_diff (
    .row(row), .refgrp(refgrp), .diffs(diffs_now));

  msad_stage #(.NUM_SUMS(NUM_SUMS), .GROUP_LEN(GROUP_LEN), .PIPE_EN(PIPE_EN)) u_stage (
    .clk(clk), .rst(rst), .load(stage_load), .d_in(diffs_now),
    .v_out(out_valid), .d_out(diffs_held));

  msad_sum #(.NUM_SUMS(NUM_SUMS), .GROUP_LEN(GROUP_LEN), .SUM_W(SUM_W)) u_sum (
    .diffs(diffs_held), .sums(sums));

  assign sad_out = sums;

endmodule

// File: rtl/msad_chk.sv
module msad_chk #(
  parameter int unsigned NUM_SUMS  = 8,
  parameter int unsigned GROUP_LEN = 4,
  parameter int unsigned SUM_W     = 16,
  parameter int unsigned ELEM_W    = 8,
  parameter bit          PIPE_EN   = 1'b1
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       in_valid,
  input logic                       stage_load,
  input logic                       out_valid,
  input logic [NUM_SUMS*SUM_W-1:0]  sad_out
);

  localparam int unsigned LANE_MAX = GROUP_LEN * ((1 << ELEM_W) - 1);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !out_valid); // R7

  genvar k;
  generate
    for (k = 0; k < NUM_SUMS; k++) begin : g_lane
      AST_LANE_BOUND: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (sad_out[k*SUM_W +: SUM_W] <= SUM_W'(LANE_MAX))); // R4
    end
    if (PIPE_EN) begin : g_piped
      AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        stage_load |=> out_valid); // R5
      AST_IDLE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R5
      AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        !stage_load |=> $stable(sad_out)); // R6
    end else begin : g_comb
      AST_COMB_VALID: assert property (@(posedge clk) disable iff (rst)
        out_valid == in_valid); // R8
    end
  endgenerate

endmodule

bind msad_unit msad_chk #(
  .NUM_SUMS(NUM_SUMS), .GROUP_LEN(GROUP_LEN), .SUM_W(SUM_W),
  .ELEM_W(msad_pkg::ELEM_W), .PIPE_EN(PIPE_EN)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .stage_load(stage_load),
  .out_valid(out_valid), .sad_out(sad_out)
);

// File: tb/sim_msad_unit.sv
`timescale 1ns/1ps
module sim_msad_unit;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [2:0]   ctrl = '0;
  logic [127:0] src_a = '0, src_b = '0;
  logic         ov0, ov1;
  logic [127:0] so0, so1;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  msad_unit #(.PIPE_EN(1'b1)) u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .ctrl(ctrl),
    .src_a(src_a), .src_b(src_b), .out_valid(ov0), .sad_out(so0));
  msad_unit #(.PIPE_EN(1'b0)) u1 (.clk(clk), .rst(rst), .in_valid(in_valid), .ctrl(ctrl),
    .src_a(src_a), .src_b(src_b), .out_valid(ov1), .sad_out(so1));

  // Reference model: signed difference then magnitude, written independently.
  function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                         input logic [2:0] c);
    logic [127:0] r;
    int ofs, grp, acc, d;
    r   = '0;
    ofs = c[2] ? 4 : 0;
    grp = 4 * int'(c[1:0]);
    for (int k = 0; k < 8; k++) begin
      acc = 0;
      for (int j = 0; j < 4; j++) begin
        d = int'(a[8*(ofs+k+j) +: 8]) - int'(b[8*(grp+j) +: 8]);
        acc += (d < 0) ? -d : d;
      end
      r[16*k +: 16] = 16'(acc);
    end
    return r;
  endfunction

  task automatic chk_v(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_b(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // One valid operation, then an idle cycle with scrambled inputs.
  task automatic run_op(input logic [127:0] a, input logic [127:0] b, input logic [2:0] c,
                        input string req);
    logic [127:0] exp;
    exp = model(a, b, c);
    @(negedge clk);
    in_valid = 1'b1; src_a = a; src_b = b; ctrl = c;
    #1;
    chk_b("R8 comb valid", ov1, 1'b1);
    chk_v({req, " R8 comb result"}, so1, exp);
    @(negedge clk);
    chk_b("R5 valid latency", ov0, 1'b1);
    chk_v({req, " R1 piped result"}, so0, exp);
    in_valid = 1'b0; src_a = rnd128(); src_b = rnd128(); ctrl = 3'($urandom);
    #1;
    chk_b("R8 comb idle", ov1, 1'b0);
    @(negedge clk);
    chk_b("R5 idle valid", ov0, 1'b0);
    chk_v("R6 hold while idle", so0, exp);
  endtask

  initial begin
    logic [127:0] a, b, ramp;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk_b("R7 reset valid", ov0, 1'b0);
    rst = 1'b0;

    // R4: all zero, and the 1020 upper bound on every lane.
    run_op('0, '0, 3'd0, "R4 zeros");
    run_op({16{8'hFF}}, '0, 3'd5, "R4 max");
    run_op('0, {16{8'hFF}}, 3'd2, "R4 max rev");

    // R2/R3: ramp row exposes offset and group selection for every code.
    for (int i = 0; i < 16; i++) ramp[8*i +: 8] = 8'(i * 17);
    for (int c = 0; c < 8; c++) run_op(ramp, ~ramp, 3'(c), "R2 R3 ramp");
    // Single marker byte in the reference group.
    for (int g = 0; g < 4; g++) begin
      b = '0; b[8*(4*g+1) +: 8] = 8'hC8;
      run_op(ramp, b, {1'b1, 2'(g)}, "R3 marker");
      run_op(ramp, b, {1'b0, 2'(g)}, "R2 marker");
    end

    // R7: reset asserted with a valid input clears out_valid.
    @(negedge clk);
    in_valid = 1'b1; rst = 1'b1; src_a = rnd128(); src_b = rnd128();
    @(negedge clk);
    chk_b("R7 reset over valid", ov0, 1'b0);
    in_valid = 1'b0; rst = 1'b0;

    // Random stimulus, R1.
    for (int n = 0; n < 300; n++) begin
      a = rnd128(); b = rnd128();
      run_op(a, b, 3'($urandom), "R1 random");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule